// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps in-flight instructions in program order inside a circular buffer. Each slot carries a sequence number, a program counter, the following program counter, a ready-to-commit flag and a squashed flag. One instruction can be allocated per cycle at the tail. One can be retired per cycle at the head, once its ready flag is set. A completion port raises the ready flag of any slot by index. The allocation index output tells the issuing logic which slot a new instruction lands in.

A squash request names a sequence number. Instructions younger than that number are not dropped at once. A walker starts at the newest entry and moves toward the oldest, handling at most `SQUASH_WIDTH` entries per cycle. It tags each entry it visits as squashed and ready, so that the entry drains out through ordinary retirement. The walk ends at the first entry whose sequence number equals the squash number, or after it has handled the oldest entry. A done flag reports when the walk has ended. No allocation is taken while a walk runs. Retirement goes on during the walk.

Top module: `rob_walk_squash`

## Requirements
- R1: After reset the buffer is empty: `freeCount` equals DEPTH, `headReady` is 0, `squashDone` is 1 and `walkError` is 0.
- R2: `allocAccept` is 1 exactly when `allocValid` is 1, the buffer is not full, `squashDone` is 1 and `squashReq` is 0. An accepted allocation stores its fields in slot `allocIdx` and adds one to the occupancy. From the next cycle `tailSeq` and `tailPc` show that entry. An allocation offered while the buffer is full is refused and changes nothing.
- R3: `freeCount` always equals DEPTH minus the number of held entries.
- R4: `headReady` is 0 while the buffer is empty. Otherwise it equals the ready flag of the oldest entry. A `completeValid` pulse sets the ready flag of slot `completeIdx`. A newly allocated entry starts with its ready flag and its squashed flag clear.
- R5: `retireAccept` equals `retireReq` AND `headReady`. An accepted retirement removes the oldest entry, so the next-oldest entry shows on the head outputs one cycle later.
- R6: A `squashReq` that arrives while `squashDone` is 1 latches `squashSeq` and starts a walk at the newest entry. `squashDone` reads 0 from the next cycle unless no entry remains. A `squashReq` that arrives while a walk is running is ignored.
- R7: Each cycle of a walk handles up to SQUASH_WIDTH entries, from newest to oldest. Each handled entry gets both its squashed flag and its ready flag set. It later retires with `headSquashed` equal to 1.
- R8: The walk stops at an entry whose sequence number equals the latched squash number. That entry is left unmarked, and `squashDone` returns to 1 after the cycle in which that entry is reached.
- R9: If no entry matches, the walk marks the oldest entry, then ends and sets `squashDone`.
- R10: `walkError` is set when the walk marks an entry whose sequence number is not greater than the squash number. It stays set until the next accepted squash request.
- R11: While a walk runs, and in the cycle a squash request is accepted, `allocAccept` is 0. Retirement is still accepted during these cycles.
- R12: The head and tail indices wrap modulo DEPTH. Slots are handed out in the order 0, 1, …, DEPTH-1, 0, and so on. A separate occupancy count tells a full buffer from an empty one.
- R13: A squash request accepted while the buffer is empty ends at once, and `squashDone` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Offer of a new instruction |
| allocSeq | input | SEQ_W | Sequence number of the offered instruction |
| allocPc | input | PC_W | Program counter of the offered instruction |
| allocNextPc | input | PC_W | Following program counter of the offered instruction |
| allocAccept | output | 1 | Offer taken this cycle |
| allocIdx | output | $clog2(DEPTH) | Slot the next allocation will occupy |
| completeValid | input | 1 | Set the ready flag of a slot |
| completeIdx | input | $clog2(DEPTH) | Slot to mark ready |
| retireReq | input | 1 | Request to retire the oldest entry |
| retireAccept | output | 1 | Retirement taken this cycle |
| squashReq | input | 1 | Start a squash walk |
| squashSeq | input | SEQ_W | Sequence number bounding the squash |
| headReady | output | 1 | Oldest entry exists and is ready |
| headSquashed | output | 1 | Squashed flag of the oldest entry |
| headSeq | output | SEQ_W | Sequence number of the oldest entry |
| headPc | output | PC_W | Program counter of the oldest entry |
| headNextPc | output | PC_W | Following program counter of the oldest entry |
| tailSeq | output | SEQ_W | Sequence number of the newest entry |
| tailPc | output | PC_W | Program counter of the newest entry |
| freeCount | output | $clog2(DEPTH+1) | Number of unused slots |
| squashDone | output | 1 | No squash walk in progress |
| walkError | output | 1 | A walked entry was not younger than the squash number |

## Verification
A wrong walk pointer or remaining-entry count shows up only later, when the entries drain. A slot that should have been squashed then reaches the head with `headReady` low and `headSquashed` clear, or a slot that should have survived shows up marked. The bench therefore retires every entry after each squash and checks both flags on each one. A count that drifts shows at `freeCount` one cycle after the slip. A done flag that rises too early or too late is caught by sampling `squashDone` on each walk cycle, against the number of cycles worked out from the number of entries and SQUASH_WIDTH.

// File: rtl/rob_walk_pkg.sv
package rob_walk_pkg;
  // Strobes issued by the control to the entry store each cycle.
  typedef struct packed {
    logic allocEn;
    logic retireEn;
  } robStrobes_t;
endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_walk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobes_t       strobes,
  input  logic [DEPTH-1:0]  markMask,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic [PC_W-1:0]   allocPc,
  input  logic [PC_W-1:0]   allocNextPc,
  input  logic              completeValid,
  input  logic [IDX_W-1:0]  completeIdx,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic [CNT_W-1:0]  count,
  output logic [SEQ_W-1:0]  entSeq [DEPTH],
  output logic              headReady,
  output logic              headSquashed,
  output logic [SEQ_W-1:0]  headSeq,
  output logic [PC_W-1:0]   headPc,
  output logic [PC_W-1:0]   headNextPc,
  output logic [SEQ_W-1:0]  tailSeq,
  output logic [PC_W-1:0]   tailPc,
  output logic [CNT_W-1:0]  freeCount
);

  logic [IDX_W-1:0] headQ, tailQ, newestIdx;
  logic [CNT_W-1:0] countQ;
  logic [SEQ_W-1:0] seqQ  [DEPTH];
  logic [PC_W-1:0]  pcQ   [DEPTH];
  logic [PC_W-1:0]  npcQ  [DEPTH];
  logic [DEPTH-1:0] rdyQ, sqQ;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(DEPTH - 1)) ? '0 : v + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] prevIdx(input logic [IDX_W-1:0] v);
    return (v == '0) ? IDX_W'(DEPTH - 1) : v - IDX_W'(1);
  endfunction

  // Ring pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobes.allocEn)  tailQ <= nextIdx(tailQ);
      if (strobes.retireEn) headQ <= nextIdx(headQ);
      case ({strobes.allocEn, strobes.retireEn})
        2'b10:   countQ <= countQ + CNT_W'(1);
        2'b01:   countQ <= countQ - CNT_W'(1);
        default: countQ <= countQ;
      endcase
    end
  end

  // Per-slot storage
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic allocHit, completeHit;
    assign allocHit    = strobes.allocEn && (tailQ == IDX_W'(i));
    assign completeHit = completeValid && (completeIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        seqQ[i] <= '0;
        pcQ[i]  <= '0;
        npcQ[i] <= '0;
        rdyQ[i] <= 1'b0;
        sqQ[i]  <= 1'b0;
      end else if (allocHit) begin
        seqQ[i] <= allocSeq;
        pcQ[i]  <= allocPc;
        npcQ[i] <= allocNextPc;
        rdyQ[i] <= 1'b0;
        sqQ[i]  <= 1'b0;
      end else begin
        if (markMask[i]) begin
          rdyQ[i] <= 1'b1;
          sqQ[i]  <= 1'b1;
        end
        if (completeHit) rdyQ[i] <= 1'b1;
      end
    end

    assign entSeq[i] = seqQ[i];

    AST_MARK_STICKS: assert property (@(posedge clk) disable iff (!rstN)
      (markMask[i] && !allocHit) |=> (rdyQ[i] && sqQ[i])); // R7
  end

  assign newestIdx    = prevIdx(tailQ);
  assign headIdx      = headQ;
  assign tailIdx      = tailQ;
  assign count        = countQ;
  assign freeCount    = CNT_W'(DEPTH) - countQ;
  assign headReady    = (countQ != '0) && rdyQ[headQ];
  assign headSquashed = sqQ[headQ];
  assign headSeq      = seqQ[headQ];
  assign headPc       = pcQ[headQ];
  assign headNextPc   = npcQ[headQ];
  assign tailSeq      = seqQ[newestIdx];
  assign tailPc       = pcQ[newestIdx];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn |-> (countQ != CNT_W'(DEPTH))); // R2

  AST_RETIRE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retireEn |-> ((countQ != '0) && rdyQ[headQ])); // R5

  AST_OCCUPANCY_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn && !strobes.retireEn |=> countQ == $past(countQ) + CNT_W'(1)); // R3

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ((countQ == '0) || (countQ == CNT_W'(DEPTH))) |-> (headQ == tailQ)); // R12

endmodule

// File: rtl/rob_ctl.sv
module rob_ctl
  import rob_walk_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 16,
  parameter int SQUASH_WIDTH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              retireReq,
  input  logic              squashReq,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              headReady,
  input  logic [CNT_W-1:0]  count,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [SEQ_W-1:0]  entSeq [DEPTH],
  output robStrobes_t       strobes,
  output logic [DEPTH-1:0]  markMask,
  output logic              allocAccept,
  output logic              retireAccept,
  output logic              squashDone,
  output logic              walkError
);

  logic             doneQ, errQ;
  logic [SEQ_W-1:0] sqSeqQ;
  logic [IDX_W-1:0] ptrQ, cur;
  logic [CNT_W-1:0] leftQ, nProc, leftAfter, leftNext, countAfterRet;
  logic             stop, found, errNow, walkEnd, startAcc;

  function automatic logic [IDX_W-1:0] prevIdx(input logic [IDX_W-1:0] v);
    return (v == '0) ? IDX_W'(DEPTH - 1) : v - IDX_W'(1);
  endfunction

  assign allocAccept   = allocValid && (count != CNT_W'(DEPTH)) && doneQ && !squashReq;
  assign retireAccept  = retireReq && headReady;
  assign startAcc      = squashReq && doneQ;
  assign countAfterRet = count - CNT_W'(retireAccept);

  always_comb begin
    strobes          = '0;
    strobes.allocEn  = allocAccept;
    strobes.retireEn = retireAccept;
  end

  // Walk up to SQUASH_WIDTH entries from newest toward oldest.
  always_comb begin
    markMask = '0;
    nProc    = '0;
    stop     = 1'b0;
    found    = 1'b0;
    errNow   = 1'b0;
    cur      = ptrQ;
    if (!doneQ) begin
      for (int k = 0; k < SQUASH_WIDTH; k++) begin
        if (!stop) begin
          if (nProc >= leftQ) begin
            stop = 1'b1;
          end else if (entSeq[cur] == sqSeqQ) begin
            stop  = 1'b1;
            found = 1'b1;
          end else begin
            markMask[cur] = 1'b1;
            if (entSeq[cur] <= sqSeqQ) errNow = 1'b1;
            nProc = nProc + CNT_W'(1);
            cur   = prevIdx(cur);
          end
        end
      end
    end
  end

  assign leftAfter = leftQ - nProc;
  assign leftNext  = (retireAccept && (leftAfter != '0)) ? leftAfter - CNT_W'(1) : leftAfter;
  assign walkEnd   = found || (leftNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ  <= 1'b1;
      errQ   <= 1'b0;
      sqSeqQ <= '0;
      ptrQ   <= '0;
      leftQ  <= '0;
    end else if (startAcc) begin
      sqSeqQ <= squashSeq;
      ptrQ   <= prevIdx(tailIdx);
      leftQ  <= countAfterRet;
      doneQ  <= (countAfterRet == '0);
      errQ   <= 1'b0;
    end else if (!doneQ) begin
      ptrQ  <= cur;
      leftQ <= leftNext;
      if (walkEnd) doneQ <= 1'b1;
      if (errNow)  errQ  <= 1'b1;
    end
  end

  assign squashDone = doneQ;
  assign walkError  = errQ;

  AST_NO_ALLOC_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (!doneQ || squashReq) |-> !strobes.allocEn); // R11

  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (!doneQ) |-> ($countones(markMask) <= SQUASH_WIDTH)); // R7

  AST_IDLE_NO_MARK: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (markMask == '0)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && (countAfterRet != '0)) |=> !squashDone); // R6

endmodule

// File: rtl/rob_walk_squash.sv
module rob_walk_squash
  import rob_walk_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 16,
  parameter int PC_W         = 32,
  parameter int SQUASH_WIDTH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [SEQ_W-1:0] allocSeq,
  input  logic [PC_W-1:0]  allocPc,
  input  logic [PC_W-1:0]  allocNextPc,
  output logic             allocAccept,
  output logic [IDX_W-1:0] allocIdx,
  input  logic             completeValid,
  input  logic [IDX_W-1:0] completeIdx,
  input  logic             retireReq,
  output logic             retireAccept,
  input  logic             squashReq,
  input  logic [SEQ_W-1:0] squashSeq,
  output logic             headReady,
  output logic             headSquashed,
  output logic [SEQ_W-1:0] headSeq,
  output logic [PC_W-1:0]  headPc,
  output logic [PC_W-1:0]  headNextPc,
  output logic [SEQ_W-1:0] tailSeq,
  output logic [PC_W-1:0]  tailPc,
  output logic [CNT_W-1:0] freeCount,
  output logic             squashDone,
  output logic             walkError
);

  robStrobes_t      strobes;
  logic [DEPTH-1:0] markMask;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [CNT_W-1:0] count;
  logic [SEQ_W-1:0] entSeq [DEPTH];

  rob_ctl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQUASH_WIDTH(SQUASH_WIDTH)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .allocValid   (allocValid),
    .retireReq    (retireReq),
    .squashReq    (squashReq),
    .squashSeq    (squashSeq),
    .headReady    (headReady),
    .count        (count),
    .tailIdx      (tailIdx),
    .entSeq       (entSeq),
    .strobes      (strobes),
    .markMask     (markMask),
    .allocAccept  (allocAccept),
    .retireAccept (retireAccept),
    .squashDone   (squashDone),
    .walkError    (walkError)
  );

  rob_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_store (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .markMask      (markMask),
    .allocSeq      (allocSeq),
    .allocPc       (allocPc),
    .allocNextPc   (allocNextPc),
    .completeValid (completeValid),
    .completeIdx   (completeIdx),
    .headIdx       (headIdx),
    .tailIdx       (tailIdx),
    .count         (count),
    .entSeq        (entSeq),
    .headReady     (headReady),
    .headSquashed  (headSquashed),
    .headSeq       (headSeq),
    .headPc        (headPc),
    .headNextPc    (headNextPc),
    .tailSeq       (tailSeq),
    .tailPc        (tailPc),
    .freeCount     (freeCount)
  );

  assign allocIdx = tailIdx;

  AST_HEAD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    retireAccept |-> (freeCount != CNT_W'(DEPTH))); // R5

endmodule

// File: tb/sim_rob_walk_squash.sv
module sim_rob_walk_squash;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int SQW   = 2;

  // {seq, pc, expected freeCount after}
  localparam logic [51:0] ALLOC_TBL [8] = '{
    {16'd10, 32'h0000_0100, 4'd7}, {16'd11, 32'h0000_0104, 4'd6},
    {16'd12, 32'h0000_0108, 4'd5}, {16'd13, 32'h0000_010C, 4'd4},
    {16'd14, 32'h0000_0110, 4'd3}, {16'd15, 32'h0000_0114, 4'd2},
    {16'd16, 32'h0000_0118, 4'd1}, {16'd17, 32'h0000_011C, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic allocValid, completeValid, retireReq, squashReq;
  logic [SEQ_W-1:0] allocSeq, squashSeq;
  logic [PC_W-1:0] allocPc, allocNextPc;
  logic [2:0] completeIdx;
  logic allocAccept, retireAccept, headReady, headSquashed, squashDone, walkError;
  logic [2:0] allocIdx;
  logic [SEQ_W-1:0] headSeq, tailSeq;
  logic [PC_W-1:0] headPc, headNextPc, tailPc;
  logic [3:0] freeCount;

  int checks = 0;
  int errors = 0;
  int bHead = 0;
  int bTail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_walk_squash #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .SQUASH_WIDTH(SQW)) u0 (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocSeq(allocSeq), .allocPc(allocPc),
    .allocNextPc(allocNextPc), .allocAccept(allocAccept), .allocIdx(allocIdx),
    .completeValid(completeValid), .completeIdx(completeIdx),
    .retireReq(retireReq), .retireAccept(retireAccept),
    .squashReq(squashReq), .squashSeq(squashSeq),
    .headReady(headReady), .headSquashed(headSquashed), .headSeq(headSeq),
    .headPc(headPc), .headNextPc(headNextPc), .tailSeq(tailSeq), .tailPc(tailPc),
    .freeCount(freeCount), .squashDone(squashDone), .walkError(walkError)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic allocOne(input logic [15:0] seq, input logic [31:0] pc, input logic expAcc);
    allocValid = 1'b1; allocSeq = seq; allocPc = pc; allocNextPc = pc + 32'd4;
    #1;
    chk(allocAccept, expAcc, "R2 allocAccept");
    if (expAcc) chk(allocIdx, bTail, "R12 allocIdx");
    @(negedge clk);
    allocValid = 1'b0;
    if (expAcc) begin
      bTail = (bTail + 1) % DEPTH;
      chk(tailSeq, seq, "R2 tailSeq");
      chk(tailPc, pc, "R2 tailPc");
    end
  endtask

  task automatic completeSlot(input int idx);
    completeValid = 1'b1; completeIdx = idx[2:0];
    @(negedge clk);
    completeValid = 1'b0;
  endtask

  task automatic retireOne(input logic [15:0] seq, input logic sq, input string req);
    chk(headSeq, seq, {req, " headSeq"});
    chk(headSquashed, sq, {req, " headSquashed"});
    chk(headReady, 1'b1, {req, " headReady"});
    retireReq = 1'b1;
    #1;
    chk(retireAccept, 1'b1, "R5 retireAccept");
    @(negedge clk);
    retireReq = 1'b0;
    bHead = (bHead + 1) % DEPTH;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; allocValid = 1'b0; completeValid = 1'b0; retireReq = 1'b0;
    squashReq = 1'b0; allocSeq = '0; squashSeq = '0; allocPc = '0;
    allocNextPc = '0; completeIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(freeCount, 8, "R1 freeCount");
    chk(headReady, 0, "R1 headReady");
    chk(squashDone, 1, "R1 squashDone");
    chk(walkError, 0, "R1 walkError");

    // Table walk: fill the buffer (R2, R3, R12)
    for (int i = 0; i < 8; i++) begin
      allocOne(ALLOC_TBL[i][51:36], ALLOC_TBL[i][35:4], 1'b1);
      chk(freeCount, ALLOC_TBL[i][3:0], "R3 freeCount");
    end

    // Full: refused, nothing changes (R2)
    allocOne(16'd99, 32'hDEAD_0000, 1'b0);
    chk(freeCount, 0, "R2 full freeCount");
    chk(tailSeq, 17, "R2 full tailSeq");

    // Head not ready (R4, R5)
    chk(headReady, 0, "R4 head not ready");
    chk(headSeq, 10, "R4 headSeq");
    retireReq = 1'b1; #1;
    chk(retireAccept, 0, "R5 refuse unready");
    @(negedge clk); retireReq = 1'b0;
    chk(freeCount, 0, "R5 occupancy kept");

    completeSlot(0);
    chk(headPc, 32'h100, "R4 headPc");
    chk(headNextPc, 32'h104, "R4 headNextPc");
    retireOne(10, 0, "R5");
    chk(headSeq, 11, "R5 next head");
    chk(freeCount, 1, "R3 after retire");

    allocOne(16'd18, 32'h0000_0120, 1'b1); // lands in slot 0 (R12 wrap)
    chk(freeCount, 0, "R12 full after wrap");
    completeSlot(bHead);
    retireOne(11, 0, "R5");

    // Squash at 14 (R6, R7, R8, R11)
    squashReq = 1'b1; squashSeq = 16'd14; allocValid = 1'b1; allocSeq = 16'd99;
    #1; chk(allocAccept, 0, "R11 alloc blocked at request");
    @(negedge clk); squashReq = 1'b0; allocValid = 1'b0;
    chk(squashDone, 0, "R6 done cleared");
    squashReq = 1'b1; squashSeq = 16'd11; allocValid = 1'b1;
    #1; chk(allocAccept, 0, "R11 alloc blocked in walk");
    @(negedge clk); squashReq = 1'b0; allocValid = 1'b0;
    chk(squashDone, 0, "R7 walk cycle 1");
    @(negedge clk);
    chk(squashDone, 0, "R7 walk cycle 2");
    @(negedge clk);
    chk(squashDone, 1, "R8 done on match");
    chk(walkError, 0, "R10 no error");

    chk(headReady, 0, "R6 second request ignored, 12 unmarked");
    completeSlot(bHead); retireOne(12, 0, "R6");
    chk(headReady, 0, "R6 13 unmarked");
    completeSlot(bHead); retireOne(13, 0, "R6");
    chk(headReady, 0, "R8 match entry unmarked");
    completeSlot(bHead); retireOne(14, 0, "R8");
    retireOne(15, 1, "R7");
    retireOne(16, 1, "R7");
    retireOne(17, 1, "R7");
    retireOne(18, 1, "R7");
    chk(freeCount, 8, "R3 empty");
    chk(headReady, 0, "R4 empty head");

    // No match: reaches oldest (R9)
    allocOne(16'd30, 32'h200, 1'b1);
    allocOne(16'd31, 32'h204, 1'b1);
    allocOne(16'd32, 32'h208, 1'b1);
    squashReq = 1'b1; squashSeq = 16'd5;
    @(negedge clk); squashReq = 1'b0;
    chk(squashDone, 0, "R9 started");
    @(negedge clk);
    chk(squashDone, 0, "R9 cycle 1");
    @(negedge clk);
    chk(squashDone, 1, "R9 ends at oldest");
    chk(walkError, 0, "R9 no error");
    retireOne(30, 1, "R9");
    retireOne(31, 1, "R9");
    retireOne(32, 1, "R9");

    // Error: entries older than squash number (R10)
    allocOne(16'd50, 32'h300, 1'b1);
    allocOne(16'd51, 32'h304, 1'b1);
    squashReq = 1'b1; squashSeq = 16'd60;
    @(negedge clk); squashReq = 1'b0;
    @(negedge clk);
    chk(walkError, 1, "R10 error raised");
    chk(squashDone, 1, "R10 walk over");
    retireOne(50, 1, "R10");
    retireOne(51, 1, "R10");
    chk(walkError, 1, "R10 error sticky");

    // Squash on empty (R13)
    squashReq = 1'b1; squashSeq = 16'd0;
    @(negedge clk); squashReq = 1'b0;
    chk(squashDone, 1, "R13 empty squash done");
    chk(walkError, 0, "R10 cleared by new squash");

    // Wrap + retire during squash (R11, R12)
    allocOne(16'd70, 32'h400, 1'b1);
    allocOne(16'd71, 32'h404, 1'b1);
    allocOne(16'd72, 32'h408, 1'b1);
    allocOne(16'd73, 32'h40C, 1'b1);
    completeSlot(bHead);
    squashReq = 1'b1; squashSeq = 16'd71; retireReq = 1'b1;
    #1; chk(retireAccept, 1, "R11 retire during squash");
    @(negedge clk); squashReq = 1'b0; retireReq = 1'b0;
    bHead = (bHead + 1) % DEPTH;
    chk(headSeq, 71, "R11 head advanced");
    chk(squashDone, 0, "R6 walk running");
    @(negedge clk);
    chk(squashDone, 0, "R7 walk cycle 1");
    @(negedge clk);
    chk(squashDone, 1, "R8 match after wrap");
    chk(headReady, 0, "R8 71 unmarked");
    completeSlot(bHead); retireOne(71, 0, "R8");
    retireOne(72, 1, "R7");
    retireOne(73, 1, "R7");
    chk(freeCount, 8, "R12 drained");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule